// File: doc/BRIEF.md
# Wavetable Serial Audio Mixer

This block receives PCM audio from an external synthesizer over a three-wire serial link and adds it, in the digital domain, to the playback samples headed for the codec's DAC. The link has a serial data line and a left/right framing line coming in, and a master clock going out to the synthesizer. No bit clock crosses the link. The receiver derives its own bit timing from the master clock it generates.

The three link lines share pads with three lines of a parallel external data bus. A configuration enable selects which function the pads carry. Two control bits support power saving. One stops the master clock. The other holds the synthesizer in reset through an active-low output. The received left and right words are held and summed into each playback sample with saturation. Whenever the port is off or its clock is stopped, the held audio is cleared, so only silence is mixed.

Top module: `wt_serial_mixer`

## Requirements
- R1: While `wt_en_i` is low, the pads pass the bus straight through: `pad_out_o`=`bus_dout_i`, `pad_oe_o`=`bus_oe_i`, `bus_din_o`=`pad_in_i`. While it is high, pad 2 (bus bit 7) is serial data in, pad 1 (bus bit 6) is framing in, and pad 0 (bus bit 5) drives the master clock. In that case `pad_oe_o`=3'b001, `pad_out_o[2:1]`=0 and `bus_din_o`=0.
- R2: While the port is enabled and the clock is not disabled, `pad_out_o[0]` toggles every `MCLK_HALF` clock cycles (every cycle by default). One bit period is 6 master-clock periods.
- R3: While `mclk_dis_i` is high, `pad_out_o[0]` stays low.
- R4: `synth_rst_no` goes low one cycle after `synth_rst_i` is high and stays low while that bit remains set. It returns high one cycle after the bit clears.
- R5: A word starts on the bit period after the framing input changes level. It is 16 bits, MSB first, two's complement. The word goes to the left channel if framing changed to high and to the right channel if it changed to low.
- R6: One cycle after `play_valid_i`, `mix_valid_o` is high. At the same time `mix_l_o`/`mix_r_o` equal the playback sample plus the last complete received word of that channel.
- R7: The sum saturates at +32767 (16'h7FFF) and -32768 (16'h8000) instead of wrapping.
- R8: While the port is disabled or the master clock is stopped, the held words are zero. Playback then passes through unchanged, including after the port is re-enabled.
- R9: During reset, `synth_rst_no` is low and the pads follow the bus. After reset, with no audio received, the mix output equals the playback input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, twice the master-clock rate by default |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wt_en_i | input | 1 | Configuration enable: pads carry the serial port |
| mclk_dis_i | input | 1 | Stop the master clock (partial power-down) |
| synth_rst_i | input | 1 | Hold the synthesizer in reset (full power-down) |
| bus_dout_i | input | 3 | Bus data to drive on the shared pads |
| bus_oe_i | input | 3 | Bus output enables for the shared pads |
| bus_din_o | output | 3 | Pad values returned to the bus |
| pad_in_i | input | 3 | Pad input levels {data, framing, clock pad} |
| pad_out_o | output | 3 | Pad output levels |
| pad_oe_o | output | 3 | Pad output enables |
| synth_rst_no | output | 1 | Active-low reset to the synthesizer |
| play_valid_i | input | 1 | Playback sample strobe |
| play_l_i | input | 16 | Playback left sample |
| play_r_i | input | 16 | Playback right sample |
| mix_valid_o | output | 1 | Mixed sample strobe |
| mix_l_o | output | 16 | Mixed left sample |
| mix_r_o | output | 16 | Mixed right sample |

## Verification
A wrong bit counter or framing decode shows up as a misaligned or mis-routed word in the next mixed sample after one frame, about 64 bit periods. A held word that is not cleared leaks into the first mixed sample after a disable. A divider or mux fault appears at the pads within one clock cycle, and a wrapping adder shows a sign flip on the very strobe that overflows. The stimulus drives every serial bit for exactly one bit period, so the result does not depend on the receiver's internal sampling phase.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int SAMPLE_W = 16;
  localparam int NCH      = 2;
  localparam int CH_L     = 0;
  localparam int CH_R     = 1;

  typedef logic signed [SAMPLE_W-1:0] sample_t;

  localparam sample_t SAT_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam sample_t SAT_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

  function automatic sample_t sat_add(sample_t a, sample_t b);
    logic signed [SAMPLE_W:0] s;
    s = {a[SAMPLE_W-1], a} + {b[SAMPLE_W-1], b};
    if (s[SAMPLE_W] != s[SAMPLE_W-1]) return s[SAMPLE_W] ? SAT_MIN : SAT_MAX;
    return s[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/wt_pin_mux.sv
module wt_pin_mux (
  input  logic       wt_en_i,
  input  logic       mclk_i,
  input  logic [2:0] bus_dout_i,
  input  logic [2:0] bus_oe_i,
  output logic [2:0] bus_din_o,
  input  logic [2:0] pad_in_i,
  output logic [2:0] pad_out_o,
  output logic [2:0] pad_oe_o,
  output logic       sdata_o,
  output logic       frame_o
);
  localparam int P_SD = 2;
  localparam int P_LR = 1;
  localparam int P_MC = 0;

  always_comb begin
    if (wt_en_i) begin
      pad_out_o       = '0;
      pad_out_o[P_MC] = mclk_i;
      pad_oe_o        = 3'b001;
      bus_din_o       = '0;
    end else begin
      pad_out_o = bus_dout_i;
      pad_oe_o  = bus_oe_i;
      bus_din_o = pad_in_i;
    end
  end

  // serial inputs read as zero when the pads belong to the bus
  assign sdata_o = wt_en_i & pad_in_i[P_SD];
  assign frame_o = wt_en_i & pad_in_i[P_LR];
endmodule

// File: rtl/wt_clk_gen.sv
module wt_clk_gen #(
  parameter int MCLK_HALF = 1,
  parameter int BIT_MCLKS = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mclk_o,
  output logic bit_tick_o
);
  localparam int BIT_CLKS = 2 * MCLK_HALF * BIT_MCLKS;
  localparam int HW = (MCLK_HALF > 1) ? $clog2(MCLK_HALF) : 1;
  localparam int BW = $clog2(BIT_CLKS);

  logic [HW-1:0] half_q;
  logic [BW-1:0] bit_q;
  logic          mclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= '0;
      bit_q  <= '0;
      mclk_q <= 1'b0;
    end else if (!run_i) begin
      half_q <= '0;
      bit_q  <= '0;
      mclk_q <= 1'b0;
    end else begin
      if (half_q == HW'(MCLK_HALF - 1)) begin
        half_q <= '0;
        mclk_q <= ~mclk_q;
      end else begin
        half_q <= half_q + 1'b1;
      end
      if (bit_q == BW'(BIT_CLKS - 1)) bit_q <= '0;
      else                            bit_q <= bit_q + 1'b1;
    end
  end

  assign mclk_o     = mclk_q;
  assign bit_tick_o = run_i && (bit_q == BW'(BIT_CLKS - 1));
endmodule

// File: rtl/wt_deser.sv
module wt_deser
  import wt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    run_i,
  input  logic    tick_i,
  input  logic    sdata_i,
  input  logic    frame_i,
  output sample_t held_o [NCH]
);
  localparam int CW = $clog2(SAMPLE_W);

  logic [SYNC_STAGES-1:0] sd_sync, lr_sync;
  logic                   sd_s, lr_s, lr_prev, busy;
  logic [CW-1:0]          cnt;
  logic                   chan;
  logic [SAMPLE_W-1:0]    shreg, shnext;
  sample_t                held_q [NCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_sync <= '0;
      lr_sync <= '0;
    end else begin
      sd_sync <= {sd_sync[SYNC_STAGES-2:0], sdata_i};
      lr_sync <= {lr_sync[SYNC_STAGES-2:0], frame_i};
    end
  end

  assign sd_s   = sd_sync[SYNC_STAGES-1];
  assign lr_s   = lr_sync[SYNC_STAGES-1];
  assign shnext = {shreg[SAMPLE_W-2:0], sd_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_prev <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      chan    <= 1'b0;
      shreg   <= '0;
      for (int i = 0; i < NCH; i++) held_q[i] <= '0;
    end else if (!run_i) begin
      lr_prev <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      for (int i = 0; i < NCH; i++) held_q[i] <= '0;
    end else if (tick_i) begin
      lr_prev <= lr_s;
      if (lr_s != lr_prev) begin
        // word starts on the next bit period; high framing = left
        busy <= 1'b1;
        cnt  <= '0;
        chan <= lr_s ? 1'(CH_L) : 1'(CH_R);
      end else if (busy) begin
        shreg <= shnext;
        if (cnt == CW'(SAMPLE_W - 1)) begin
          busy         <= 1'b0;
          held_q[chan] <= shnext;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign held_o = held_q;
endmodule

// File: rtl/wt_sat_mix.sv
module wt_sat_mix
  import wt_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    valid_i,
  input  sample_t play_i [NCH],
  input  sample_t wt_i   [NCH],
  output logic    valid_o,
  output sample_t mix_o  [NCH]
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mix_o[c] <= '0;
      else if (valid_i) mix_o[c] <= sat_add(play_i[c], wt_i[c]);
    end
  end
endmodule

// File: rtl/wt_serial_mixer.sv
module wt_serial_mixer
  import wt_pkg::*;
#(
  parameter int MCLK_HALF   = 1,
  parameter int BIT_MCLKS   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wt_en_i,
  input  logic                mclk_dis_i,
  input  logic                synth_rst_i,
  input  logic [2:0]          bus_dout_i,
  input  logic [2:0]          bus_oe_i,
  output logic [2:0]          bus_din_o,
  input  logic [2:0]          pad_in_i,
  output logic [2:0]          pad_out_o,
  output logic [2:0]          pad_oe_o,
  output logic                synth_rst_no,
  input  logic                play_valid_i,
  input  logic [SAMPLE_W-1:0] play_l_i,
  input  logic [SAMPLE_W-1:0] play_r_i,
  output logic                mix_valid_o,
  output logic [SAMPLE_W-1:0] mix_l_o,
  output logic [SAMPLE_W-1:0] mix_r_o
);
  logic    run, mclk, tick, sdata, frame;
  logic    srst_q;
  sample_t held [NCH];
  sample_t play [NCH];
  sample_t mix  [NCH];

  assign run = wt_en_i && !mclk_dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) srst_q <= 1'b0;
    else         srst_q <= ~synth_rst_i;
  end
  assign synth_rst_no = srst_q;

  wt_clk_gen #(.MCLK_HALF(MCLK_HALF), .BIT_MCLKS(BIT_MCLKS)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run),
    .mclk_o(mclk), .bit_tick_o(tick)
  );

  wt_pin_mux u_mux (
    .wt_en_i(wt_en_i), .mclk_i(mclk),
    .bus_dout_i(bus_dout_i), .bus_oe_i(bus_oe_i), .bus_din_o(bus_din_o),
    .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
    .sdata_o(sdata), .frame_o(frame)
  );

  wt_deser #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_i(tick),
    .sdata_i(sdata), .frame_i(frame), .held_o(held)
  );

  assign play[CH_L] = play_l_i;
  assign play[CH_R] = play_r_i;

  wt_sat_mix u_mix (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(play_valid_i),
    .play_i(play), .wt_i(held), .valid_o(mix_valid_o), .mix_o(mix)
  );

  assign mix_l_o = mix[CH_L];
  assign mix_r_o = mix[CH_R];
endmodule

// File: rtl/wt_serial_mixer_chk.sv
module wt_serial_mixer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wt_en_i,
  input logic        mclk_dis_i,
  input logic        synth_rst_i,
  input logic [2:0]  pad_in_i,
  input logic [2:0]  pad_out_o,
  input logic [2:0]  pad_oe_o,
  input logic [2:0]  bus_din_o,
  input logic        synth_rst_no,
  input logic [15:0] play_l_i,
  input logic        mix_valid_o,
  input logic [15:0] mix_l_o,
  input logic [15:0] held_l,
  input logic [15:0] held_r
);
  assert_link_inputs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wt_en_i |-> (pad_oe_o[2:1] == 2'b00 && bus_din_o == 3'b000));

  assert_bus_passthru_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wt_en_i |-> bus_din_o == pad_in_i);

  assert_mclk_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wt_en_i && mclk_dis_i) |=> (!pad_out_o[0] || !wt_en_i));

  assert_synth_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    synth_rst_i |=> !synth_rst_no);

  assert_held_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wt_en_i && !mclk_dis_i) |=> (held_l == 16'h0 && held_r == 16'h0));

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mix_valid_o && !$past(play_l_i[15]) && !$past(held_l[15])) |-> !mix_l_o[15]);
endmodule

bind wt_serial_mixer wt_serial_mixer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wt_en_i(wt_en_i), .mclk_dis_i(mclk_dis_i),
  .synth_rst_i(synth_rst_i), .pad_in_i(pad_in_i), .pad_out_o(pad_out_o),
  .pad_oe_o(pad_oe_o), .bus_din_o(bus_din_o), .synth_rst_no(synth_rst_no),
  .play_l_i(play_l_i), .mix_valid_o(mix_valid_o), .mix_l_o(mix_l_o),
  .held_l(held[0]), .held_r(held[1])
);

// File: tb/wt_serial_mixer_bench.sv
module wt_serial_mixer_bench;
  localparam int BIT_CLKS = 12;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wt_en = 1'b0, mclk_dis = 1'b0, synth_rst = 1'b0;
  logic [2:0]  bus_dout = '0, bus_oe = '0, bus_din, pad_out, pad_oe;
  logic        sd = 1'b0, lr = 1'b0, p0 = 1'b0;
  logic        synth_rst_n, play_valid = 1'b0, mix_valid;
  logic [15:0] play_l = '0, play_r = '0, mix_l, mix_r;
  int          n_chk = 0, n_err = 0;
  logic [15:0] exp_l = '0, exp_r = '0;

  typedef struct {
    string       req;
    logic [15:0] l;
    logic [15:0] r;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  wt_serial_mixer u_wt_serial_mixer (
    .clk_i(clk), .rst_ni(rst_n), .wt_en_i(wt_en), .mclk_dis_i(mclk_dis),
    .synth_rst_i(synth_rst), .bus_dout_i(bus_dout), .bus_oe_i(bus_oe),
    .bus_din_o(bus_din), .pad_in_i({sd, lr, p0}), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .synth_rst_no(synth_rst_n), .play_valid_i(play_valid),
    .play_l_i(play_l), .play_r_i(play_r), .mix_valid_o(mix_valid),
    .mix_l_o(mix_l), .mix_r_o(mix_r)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sat(logic [15:0] a, logic [15:0] b);
    int s;
    s = $signed(a) + $signed(b);
    if (s > 32767)  return 16'h7FFF;
    if (s < -32768) return 16'h8000;
    return s[15:0];
  endfunction

  // driver: push expected mix, then strobe one playback sample
  task automatic push_mix(string req, logic [15:0] pl, logic [15:0] pr);
    exp_t e;
    e.req = req; e.l = sat(pl, exp_l); e.r = sat(pr, exp_r);
    sb.push_back(e);
    @(negedge clk);
    play_l = pl; play_r = pr; play_valid = 1'b1;
    @(negedge clk);
    play_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // one 64-bit-period frame; each bit held for exactly one bit period
  task automatic send_frame(logic [15:0] l, logic [15:0] r);
    for (int w = 0; w < 64; w++) begin
      @(negedge clk);
      lr = (w < 32);
      if (w >= 1 && w <= 16)       sd = l[16 - w];
      else if (w >= 33 && w <= 48) sd = r[48 - w];
      else                         sd = 1'b0;
      repeat (BIT_CLKS - 1) @(negedge clk);
    end
    exp_l = l; exp_r = r;
    repeat (4) @(negedge clk);
  endtask

  task automatic count_toggles(string req, int cycles, int expct);
    int   t = 0;
    logic prev;
    @(negedge clk);
    prev = pad_out[0];
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pad_out[0] != prev) t++;
      prev = pad_out[0];
    end
    chk(req, t, expct);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && mix_valid) begin
      if (sb.size() == 0) chk("R6 unexpected strobe", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.req, " left"},  mix_l, e.l);
        chk({e.req, " right"}, mix_r, e.r);
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    bus_dout = 3'b011;
    repeat (3) @(negedge clk);
    chk("R9 synth reset during reset", synth_rst_n, 0);
    chk("R9 pads follow bus in reset", pad_out, 3'b011);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 synth reset released", synth_rst_n, 1);
    push_mix("R9 passthrough", 16'h1111, 16'hF000);

    // R1 bus mode
    bus_dout = 3'b101; bus_oe = 3'b110; sd = 1'b1; lr = 1'b1; p0 = 1'b0;
    @(negedge clk);
    chk("R1 bus out", pad_out, 3'b101);
    chk("R1 bus oe", pad_oe, 3'b110);
    chk("R1 bus in", bus_din, 3'b110);
    sd = 1'b0; lr = 1'b0;

    // R1 serial-port mode
    wt_en = 1'b1; bus_dout = 3'b111; bus_oe = 3'b111;
    @(negedge clk);
    chk("R1 port oe", pad_oe, 3'b001);
    chk("R1 port data pads low", pad_out[2:1], 0);
    chk("R1 bus in masked", bus_din, 0);

    count_toggles("R2 mclk running", 24, 24);

    synth_rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 synth held", synth_rst_n, 0);
    synth_rst = 1'b0;
    @(negedge clk);
    chk("R4 synth released", synth_rst_n, 1);

    send_frame(16'h1234, 16'hFFFE);
    push_mix("R5 captured words", 16'h0000, 16'h0000);
    push_mix("R6 sum", 16'h0100, 16'h0005);

    send_frame(16'h7000, 16'h9000);
    push_mix("R7 saturate", 16'h2000, 16'hA000);
    push_mix("R7 in range", 16'h0FFF, 16'h7000);

    mclk_dis = 1'b1;
    @(negedge clk);
    count_toggles("R3 mclk stopped", 24, 0);
    chk("R3 mclk low", pad_out[0], 0);
    exp_l = '0; exp_r = '0;
    push_mix("R8 cleared on stop", 16'h0042, 16'hFF00);
    mclk_dis = 1'b0;

    send_frame(16'h0400, 16'h8001);
    push_mix("R5 second frame", 16'h0001, 16'hFFFF);
    wt_en = 1'b0;
    repeat (3) @(negedge clk);
    wt_en = 1'b1;
    exp_l = '0; exp_r = '0;
    repeat (3) @(negedge clk);
    push_mix("R8 cleared on disable", 16'h0001, 16'h0001);

    repeat (4) @(negedge clk);
    chk("R6 scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule